// File: doc/BRIEF.md
# Bus Activity Monitor with Watermarks

This block watches several independent activity sources, one per channel, and turns their raw event pulses into per-period samples and a smoothed running average. A global period counter, advanced by a period tick input, divides time into sampling windows of programmable length. During each window a channel adds a programmable weight to its sample accumulator for every event tick it sees. When the window closes, the sample is folded into an exponential average whose window length is set by a shift amount, and the accumulator starts again from zero.

Each closed sample is compared with a pair of raw watermarks. A channel raises an interrupt once the sample stays above the upper mark, or below the lower mark, for a programmed number of consecutive periods. The armed condition then disarms itself, so software must re-arm it. The freshly updated average is also compared with its own band and can raise an interrupt when it leaves that band. Software reaches every register through a flat read/write port. A single interrupt line summarizes all channels, and a global status word shows which channel is pending.

Top module: `act_mon`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The global period register at 0x004 holds the period length minus one. A sample period ends on every (value+1)-th period tick. Writing this register restarts the tick count from zero.
- R3: Channel c has its registers at 0x100 + 64*c. While control bit 31 (enable) is set, each event tick adds the weight register (offset 0x18) to the sample. The sample restarts from zero at every period end. A channel with bit 31 clear ignores events, and its average does not change.
- R4: At a period end, if control bits 31 and 18 are both set, the average at offset 0x20 becomes avg + ((sample − avg) >>> (K+1)). The difference is signed, and K is control bits 12:10. Writing offset 0x0C loads the average directly.
- R5: If the sample exceeds the upper watermark (0x04) for L consecutive periods, then with control bit 30 set, status bit 31 (offset 0x24) is set and control bit 30 clears. L is control bits 28:26 plus one.
- R6: If the sample is below the lower watermark (0x08) for L consecutive periods, then with control bit 29 set, status bit 30 is set and control bit 29 clears. L is control bits 25:23 plus one.
- R7: A sample with lower ≤ sample ≤ upper restarts both consecutive runs. A below sample restarts the above run, and an above sample restarts the below run.
- R8: After each average update, status bit 29 is set if the new average exceeds the average upper mark (0x10) and control bit 21 is set. Status bit 28 is set if the new average is below the average lower mark (0x14) and control bit 20 is set. Equality sets neither bit.
- R9: A write to the status register clears each status bit whose data bit is one. Writing all ones clears the whole register.
- R10: Global status (0x000) bit c is one while channel c has any status bit set. `irq` is high while any channel has a status bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| event_tick | input | NCH | One activity event per channel per cycle |
| period_tick | input | 1 | Advances the sampling period counter |
| irq | output | 1 | Summary interrupt |

## Verification
The assertions take the period tick, the event ticks and register writes to be synchronous single-cycle levels. They check status clearing only in cycles where no period closes, because a condition raised in that same cycle is allowed to win over the clear. The stimulus changes inputs on the falling edge. It always drives whole periods of ticks, so register writes land between periods, and it leaves at least one idle cycle between ticks. A band-resetting sample is run before each consecutive-run sweep, so no run count carries over from an earlier pattern.

// File: rtl/act_mon_pkg.sv
package act_mon_pkg;
    localparam int DATA_W     = 32;
    localparam int OFS_W      = 6;     // 64-byte register block per channel
    localparam int K_W        = 3;
    localparam int RUNF_W     = 3;
    localparam int RUN_W      = RUNF_W + 1;
    localparam int STAT_W     = 4;

    // control bit positions
    localparam int B_ENABLE   = 31;
    localparam int B_HI_ARM   = 30;
    localparam int B_LO_ARM   = 29;
    localparam int B_HI_LEN   = 26;
    localparam int B_LO_LEN   = 23;
    localparam int B_AVG_HI   = 21;
    localparam int B_AVG_LO   = 20;
    localparam int B_PERIODIC = 18;
    localparam int B_K        = 10;

    // index into the 4-bit status field (register bits 31:28)
    localparam int S_HI_RUN   = 3;
    localparam int S_LO_RUN   = 2;
    localparam int S_AVG_HI   = 1;
    localparam int S_AVG_LO   = 0;

    // per-channel offsets
    localparam logic [OFS_W-1:0] O_CTRL   = 6'h00;
    localparam logic [OFS_W-1:0] O_WM_HI  = 6'h04;
    localparam logic [OFS_W-1:0] O_WM_LO  = 6'h08;
    localparam logic [OFS_W-1:0] O_SEED   = 6'h0C;
    localparam logic [OFS_W-1:0] O_AVG_HI = 6'h10;
    localparam logic [OFS_W-1:0] O_AVG_LO = 6'h14;
    localparam logic [OFS_W-1:0] O_WEIGHT = 6'h18;
    localparam logic [OFS_W-1:0] O_AVG    = 6'h20;
    localparam logic [OFS_W-1:0] O_STAT   = 6'h24;

    // global offsets
    localparam logic [OFS_W-1:0] O_GSTAT  = 6'h00;
    localparam logic [OFS_W-1:0] O_PERIOD = 6'h04;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] wm_hi;
        logic [DATA_W-1:0] wm_lo;
        logic [DATA_W-1:0] seed;
        logic [DATA_W-1:0] avg_hi;
        logic [DATA_W-1:0] avg_lo;
        logic [DATA_W-1:0] weight;
        logic [DATA_W-1:0] avg;
        logic [DATA_W-1:0] acc;
        logic [STAT_W-1:0] stat;
        logic [RUN_W-1:0]  hi_run;
        logic [RUN_W-1:0]  lo_run;
    } chan_state_t;
endpackage

// File: rtl/act_mon_period.sv
module act_mon_period #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                period_tick,
    input  logic                wr_en,
    input  logic [PERIOD_W-1:0] wr_data,
    output logic [PERIOD_W-1:0] period_o,
    output logic [PERIOD_W-1:0] count_o,
    output logic                period_end
);
    typedef struct packed {
        logic [PERIOD_W-1:0] limit;
        logic [PERIOD_W-1:0] cnt;
    } per_state_t;

    per_state_t p_d, p_q;

    always_comb begin
        p_d        = p_q;
        period_end = period_tick && (p_q.cnt == p_q.limit);
        if (period_tick) begin
            p_d.cnt = period_end ? '0 : p_q.cnt + 1'b1;
        end
        if (wr_en) begin
            p_d.limit = wr_data;
            p_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign period_o = p_q.limit;
    assign count_o  = p_q.cnt;
endmodule

// File: rtl/act_mon_chan.sv
module act_mon_chan
    import act_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              event_tick,
    input  logic              period_end,
    output logic [DATA_W-1:0] rd_data,
    output logic [STAT_W-1:0] stat_o,
    output logic [1:0]        arm_o,
    output logic              pend_o
);
    chan_state_t s_d, s_q;

    logic                active;
    logic [DATA_W-1:0]   sample;
    logic [DATA_W-1:0]   avg_new;
    logic signed [DATA_W:0] diff;
    logic signed [DATA_W:0] step;
    logic [K_W:0]        shamt;
    logic [RUN_W-1:0]    hi_len, lo_len, hi_next, lo_next;
    logic [STAT_W-1:0]   set_v, clr_v;

    always_comb begin
        s_d     = s_q;
        set_v   = '0;
        clr_v   = '0;
        diff    = '0;
        step    = '0;
        avg_new = s_q.avg;
        active  = s_q.ctrl[B_ENABLE];
        shamt   = {1'b0, s_q.ctrl[B_K +: K_W]} + 1'b1;
        hi_len  = {1'b0, s_q.ctrl[B_HI_LEN +: RUNF_W]} + 1'b1;
        lo_len  = {1'b0, s_q.ctrl[B_LO_LEN +: RUNF_W]} + 1'b1;
        hi_next = s_q.hi_run + 1'b1;
        lo_next = s_q.lo_run + 1'b1;
        sample  = s_q.acc + ((active && event_tick) ? s_q.weight : '0);
        s_d.acc = sample;

        if (active && period_end) begin
            s_d.acc = '0;
            if (s_q.ctrl[B_PERIODIC]) begin
                // exponential average, shift-based window
                diff      = $signed({1'b0, sample}) - $signed({1'b0, s_q.avg});
                step      = diff >>> shamt;
                avg_new   = DATA_W'($signed({1'b0, s_q.avg}) + step);
                s_d.avg   = avg_new;

                // raw watermark runs
                if (sample > s_q.wm_hi) begin
                    s_d.lo_run = '0;
                    if (hi_next >= hi_len) begin
                        s_d.hi_run = '0;
                        if (s_q.ctrl[B_HI_ARM]) begin
                            set_v[S_HI_RUN]      = 1'b1;
                            s_d.ctrl[B_HI_ARM]   = 1'b0;
                        end
                    end else begin
                        s_d.hi_run = hi_next;
                    end
                end else if (sample < s_q.wm_lo) begin
                    s_d.hi_run = '0;
                    if (lo_next >= lo_len) begin
                        s_d.lo_run = '0;
                        if (s_q.ctrl[B_LO_ARM]) begin
                            set_v[S_LO_RUN]      = 1'b1;
                            s_d.ctrl[B_LO_ARM]   = 1'b0;
                        end
                    end else begin
                        s_d.lo_run = lo_next;
                    end
                end else begin
                    s_d.hi_run = '0;
                    s_d.lo_run = '0;
                end

                // average band
                if (s_q.ctrl[B_AVG_HI] && (avg_new > s_q.avg_hi)) set_v[S_AVG_HI] = 1'b1;
                if (s_q.ctrl[B_AVG_LO] && (avg_new < s_q.avg_lo)) set_v[S_AVG_LO] = 1'b1;
            end
        end

        if (wr_en) begin
            case (ofs)
                O_CTRL:   s_d.ctrl   = wr_data;
                O_WM_HI:  s_d.wm_hi  = wr_data;
                O_WM_LO:  s_d.wm_lo  = wr_data;
                O_SEED: begin
                    s_d.seed = wr_data;
                    s_d.avg  = wr_data;
                end
                O_AVG_HI: s_d.avg_hi = wr_data;
                O_AVG_LO: s_d.avg_lo = wr_data;
                O_WEIGHT: s_d.weight = wr_data;
                O_STAT:   clr_v      = wr_data[DATA_W-1 -: STAT_W];
                default:  ;
            endcase
        end
        // a condition raised this cycle wins over a clear
        s_d.stat = (s_q.stat & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (ofs)
            O_CTRL:   rd_data = s_q.ctrl;
            O_WM_HI:  rd_data = s_q.wm_hi;
            O_WM_LO:  rd_data = s_q.wm_lo;
            O_SEED:   rd_data = s_q.seed;
            O_AVG_HI: rd_data = s_q.avg_hi;
            O_AVG_LO: rd_data = s_q.avg_lo;
            O_WEIGHT: rd_data = s_q.weight;
            O_AVG:    rd_data = s_q.avg;
            O_STAT:   rd_data = {s_q.stat, {(DATA_W-STAT_W){1'b0}}};
            default:  rd_data = '0;
        endcase
    end

    assign stat_o = s_q.stat;
    assign arm_o  = {s_q.ctrl[B_HI_ARM], s_q.ctrl[B_LO_ARM]};
    assign pend_o = |s_q.stat;
endmodule

// File: rtl/act_mon.sv
module act_mon
    import act_mon_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int ADDR_W   = 12,
    parameter int PERIOD_W = 16,
    parameter int CH_BASE  = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NCH-1:0]    event_tick,
    input  logic              period_tick,
    output logic              irq
);
    localparam int BLK_W    = ADDR_W - OFS_W;
    localparam int BASE_BLK = CH_BASE / (1 << OFS_W);

    logic [OFS_W-1:0]               ofs;
    logic                           glb_sel;
    logic                           period_end;
    logic [PERIOD_W-1:0]            per_val, per_cnt;
    logic [NCH-1:0]                 ch_sel, ch_pend;
    logic [NCH-1:0][DATA_W-1:0]     ch_rd;
    logic [NCH-1:0][STAT_W-1:0]     ch_stat;
    logic [NCH-1:0][1:0]            ch_arm;

    assign ofs     = reg_addr[OFS_W-1:0];
    assign glb_sel = (reg_addr[ADDR_W-1:OFS_W] == '0);

    act_mon_period #(.PERIOD_W(PERIOD_W)) u_period (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_tick (period_tick),
        .wr_en       (reg_we && glb_sel && (ofs == O_PERIOD)),
        .wr_data     (reg_wdata[PERIOD_W-1:0]),
        .period_o    (per_val),
        .count_o     (per_cnt),
        .period_end  (period_end)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [BLK_W-1:0] BLK = BLK_W'(BASE_BLK + c);
        assign ch_sel[c] = (reg_addr[ADDR_W-1:OFS_W] == BLK);

        act_mon_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (reg_we && ch_sel[c]),
            .ofs        (ofs),
            .wr_data    (reg_wdata),
            .event_tick (event_tick[c]),
            .period_end (period_end),
            .rd_data    (ch_rd[c]),
            .stat_o     (ch_stat[c]),
            .arm_o      (ch_arm[c]),
            .pend_o     (ch_pend[c])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (glb_sel) begin
            if (ofs == O_GSTAT)       reg_rdata[NCH-1:0]      = ch_pend;
            else if (ofs == O_PERIOD) reg_rdata[PERIOD_W-1:0] = per_val;
        end
        for (int c = 0; c < NCH; c++) begin
            if (ch_sel[c]) reg_rdata = ch_rd[c];
        end
    end

    assign irq = |ch_pend;
endmodule

// File: rtl/act_mon_chk.sv
module act_mon_chk
    import act_mon_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int ADDR_W   = 12,
    parameter int PERIOD_W = 16,
    parameter int CH_BASE  = 'h100
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_we,
    input logic [ADDR_W-1:0]          reg_addr,
    input logic [31:0]                reg_wdata,
    input logic                       period_end,
    input logic [PERIOD_W-1:0]        per_val,
    input logic [PERIOD_W-1:0]        per_cnt,
    input logic [NCH-1:0][STAT_W-1:0] ch_stat,
    input logic [NCH-1:0][1:0]        ch_arm
);
    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        per_cnt <= per_val); // R2

    for (genvar c = 0; c < NCH; c++) begin : g_c
        localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(CH_BASE + c * 64 + 'h24);

        AST_NEW_STATUS_AT_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
            ((ch_stat[c] & ~$past(ch_stat[c])) != '0) |-> $past(period_end)); // R8

        AST_HI_RUN_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_stat[c][S_HI_RUN]) |-> !ch_arm[c][1]); // R5

        AST_LO_RUN_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_stat[c][S_LO_RUN]) |-> !ch_arm[c][0]); // R6

        AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == STAT_A && reg_wdata == 32'hFFFF_FFFF && !period_end)
            |=> (ch_stat[c] == '0)); // R9
    end
endmodule

bind act_mon act_mon_chk #(
    .NCH(NCH), .ADDR_W(ADDR_W), .PERIOD_W(PERIOD_W), .CH_BASE(CH_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .period_end (period_end),
    .per_val    (per_val),
    .per_cnt    (per_cnt),
    .ch_stat    (ch_stat),
    .ch_arm     (ch_arm)
);

// File: tb/act_mon_bench.sv
module act_mon_bench;
    localparam int NCH = 2;
    localparam int P   = 4;
    localparam logic [11:0] B0 = 12'h100, B1 = 12'h140;
    localparam logic [31:0] EN = 32'h8000_0000, PER = 32'h0004_0000;
    localparam logic [31:0] HI_ARM = 32'h4000_0000, LO_ARM = 32'h2000_0000;
    localparam logic [31:0] AHI_EN = 32'h0020_0000, ALO_EN = 32'h0010_0000;

    logic clk = 0, rst_n = 0, reg_we = 0, period_tick = 0;
    logic [11:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic [NCH-1:0] event_tick = 0;
    logic irq;
    int n_chk = 0, n_fail = 0;
    logic [31:0] rv, mavg;

    always #2 clk = ~clk;

    act_mon u_act_mon (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .event_tick(event_tick),
        .period_tick(period_tick), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tick(input bit e0, input bit e1);
        @(negedge clk);
        period_tick = 1; event_tick = {e1, e0};
        @(negedge clk);
        period_tick = 0; event_tick = 0;
    endtask

    task automatic run_period(input int n0, input int n1);
        for (int i = 0; i < P; i++) tick(i < n0, i < n1);
    endtask

    function automatic logic [31:0] avg_step(input logic [31:0] a, input logic [31:0] s, input int k);
        longint d;
        d = longint'(s) - longint'(a);
        d = d >>> (k + 1);
        return 32'(longint'(a) + d);
    endfunction

    task automatic irq_chk(input string tag, input logic exp);
        @(negedge clk);
        #1 chk(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(B0 + 12'h00, rv); chk("R1 ctrl", rv, 0);
        rd(B0 + 12'h20, rv); chk("R1 avg", rv, 0);
        rd(B0 + 12'h24, rv); chk("R1 status", rv, 0);
        rd(12'h000, rv);     chk("R1 global status", rv, 0);
        rd(12'h004, rv);     chk("R1 period", rv, 0);
        irq_chk("R1 irq", 0);

        // R2 period length
        wr(12'h004, P - 1);
        rd(12'h004, rv); chk("R2 period readback", rv, P - 1);
        wr(B0 + 12'h18, 4);
        wr(B0 + 12'h00, EN | PER);
        for (int i = 0; i < P - 1; i++) tick(i < 2, 0);
        rd(B0 + 12'h20, rv); chk("R2 no update before last tick", rv, 0);
        tick(0, 0);
        rd(B0 + 12'h20, rv); chk("R2 update on last tick", rv, 4);

        // R3/R4 sweep over K and sample patterns
        for (int k = 0; k < 4; k++) begin
            wr(B0 + 12'h18, 5);
            wr(B0 + 12'h0C, 20);
            wr(B0 + 12'h00, EN | PER | (k << 10));
            mavg = 20;
            rd(B0 + 12'h20, rv); chk("R4 seed", rv, 20);
            for (int j = 0; j < 6; j++) begin
                int nev;
                nev = (j * 3 + k) % 5;
                if (nev > P) nev = P;
                run_period(nev, 0);
                mavg = avg_step(mavg, 32'(nev * 5), k);
                rd(B0 + 12'h20, rv); chk($sformatf("R4 avg k=%0d j=%0d", k, j), rv, mavg);
            end
        end
        // R3 disabled channel ignores events
        wr(B0 + 12'h00, PER);
        run_period(4, 0);
        rd(B0 + 12'h20, rv); chk("R3 disabled keeps avg", rv, mavg);
        wr(B0 + 12'h00, EN);
        run_period(4, 0);
        rd(B0 + 12'h20, rv); chk("R4 no periodic keeps avg", rv, mavg);

        // raw watermark setup: hi 10, lo 4, weight 4 -> 3 ev=12 above, 0 below, 2=8 in band
        wr(B0 + 12'h04, 10);
        wr(B0 + 12'h08, 4);
        wr(B0 + 12'h18, 4);
        for (int n = 1; n <= 4; n++) begin
            wr(B0 + 12'h24, 32'hFFFF_FFFF);
            wr(B0 + 12'h00, EN | PER | HI_ARM | ((n - 1) << 26));
            run_period(2, 0);
            for (int j = 0; j < n - 1; j++) run_period(3, 0);
            irq_chk($sformatf("R5 no irq before run n=%0d", n), 0);
            run_period(3, 0);
            irq_chk($sformatf("R5 irq at run n=%0d", n), 1);
            rd(B0 + 12'h24, rv); chk("R5 status bit31", rv, 32'h8000_0000);
            rd(B0 + 12'h00, rv); chk("R5 arm cleared", rv & HI_ARM, 0);
        end
        // R9 clear
        wr(B0 + 12'h24, 32'hFFFF_FFFF);
        rd(B0 + 12'h24, rv); chk("R9 status cleared", rv, 0);
        irq_chk("R9 irq low", 0);

        for (int n = 1; n <= 4; n++) begin
            wr(B0 + 12'h24, 32'hFFFF_FFFF);
            wr(B0 + 12'h00, EN | PER | LO_ARM | ((n - 1) << 23));
            run_period(2, 0);
            for (int j = 0; j < n - 1; j++) run_period(0, 0);
            irq_chk($sformatf("R6 no irq before run n=%0d", n), 0);
            run_period(0, 0);
            rd(B0 + 12'h24, rv); chk($sformatf("R6 status bit30 n=%0d", n), rv, 32'h4000_0000);
            rd(B0 + 12'h00, rv); chk("R6 arm cleared", rv & LO_ARM, 0);
        end

        // R7 band and opposite samples restart the run (length 3)
        wr(B0 + 12'h24, 32'hFFFF_FFFF);
        wr(B0 + 12'h00, EN | PER | HI_ARM | (2 << 26));
        run_period(3, 0); run_period(3, 0); run_period(2, 0);
        run_period(3, 0); run_period(3, 0);
        irq_chk("R7 band restarts run", 0);
        run_period(0, 0); run_period(3, 0); run_period(3, 0);
        irq_chk("R7 below restarts run", 0);
        run_period(3, 0);
        irq_chk("R7 third above fires", 1);
        wr(B0 + 12'h24, 32'h8000_0000);
        rd(B0 + 12'h24, rv); chk("R9 single bit clear", rv, 0);

        // R8 average band: hi 100, lo 50, K=0
        wr(B0 + 12'h10, 100);
        wr(B0 + 12'h14, 50);
        wr(B0 + 12'h0C, 200);
        wr(B0 + 12'h00, EN | PER | AHI_EN | ALO_EN);
        mavg = 200;
        for (int j = 0; j < 3; j++) begin
            logic [31:0] exp_s;
            run_period(0, 0);
            mavg = avg_step(mavg, 0, 0);
            exp_s = (mavg < 50) ? 32'h1000_0000 : ((mavg > 100) ? 32'h2000_0000 : 0);
            rd(B0 + 12'h24, rv); chk($sformatf("R8 avg=%0d", mavg), rv, exp_s);
        end
        wr(B0 + 12'h24, 32'hFFFF_FFFF);
        wr(B0 + 12'h18, 100);
        wr(B0 + 12'h0C, 100);
        run_period(4, 0);
        rd(B0 + 12'h20, rv); chk("R8 avg rise", rv, avg_step(100, 400, 0));
        rd(B0 + 12'h24, rv); chk("R8 above band bit29", rv, 32'h2000_0000);

        // R10 global status from channel 1
        wr(B0 + 12'h24, 32'hFFFF_FFFF);
        wr(B0 + 12'h00, 0);
        wr(B1 + 12'h04, 10);
        wr(B1 + 12'h08, 4);
        wr(B1 + 12'h18, 4);
        wr(B1 + 12'h00, EN | PER | HI_ARM);
        run_period(0, 3);
        rd(12'h000, rv); chk("R10 global bit1", rv, 2);
        irq_chk("R10 irq", 1);
        wr(B1 + 12'h24, 32'hFFFF_FFFF);
        rd(12'h000, rv); chk("R10 global cleared", rv, 0);
        irq_chk("R10 irq low", 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule